// File: doc/BRIEF.md
# Five-Source Shared Memory Port Arbiter

This block lets five independent bus masters of a split program/data processor share a single memory or peripheral port. The masters are a data writer, a program writer, a data reader, a program reader and an instruction fetcher. In every cycle the block picks one requester by a fixed ranking. Stores rank above loads, and the fetcher always comes last. The block drives the winner's address, write data and write strobe onto the port and steers the port's read data back to the winner. Every other requester receives a stall.

The program-side buses carry a narrower address than the data buses. Program addresses are zero-extended before they reach the port. The port has a single ready input. When ready is low, the access in flight keeps the port, and the grant stays frozen until ready returns, so the memory never sees its address change in the middle of an access. Two pairs of requests must never be raised together: the two writers, and the program reader with the fetcher. If either pair does appear, the higher-ranked member of the pair still wins.

Top module: `harvardPortArbiter`

## Requirements
- R1: With no access waiting on ready, the grant goes to the requesting source ranked highest. The ranking, from highest to lowest, is: data write, program write, data read, program read, fetch.
- R2: The grant vector is one-hot or zero, with bit 0 = data write, bit 1 = program write, bit 2 = data read, bit 3 = program read, bit 4 = fetch. It is all zeros, and memEn is low, when nothing requests. The stall vector uses the same bit order.
- R3: Every source that requests and is not granted has its stall bit high in that cycle.
- R4: If a granted access sees memReady low, the same source keeps the grant in later cycles, whatever higher-ranked requests arrive, until a cycle with memReady high completes it. The granted source stalls while memReady is low. The hold is dropped if the held source withdraws its request.
- R5: memAddr carries the winner's address. For the three program-side sources, the 22-bit address is zero-extended, so bits 31..22 are zero.
- R6: memWe is high exactly when a writer is granted. memWdata then carries that writer's data, and it is zero otherwise.
- R7: Each read source's data output equals memRdata while that source is granted and is zero otherwise.
- R8: A granted access with memReady high completes in that same cycle: the winner's stall bit is low.
- R9: If both writers, or the program reader and the fetcher, request together, the data writer or the program reader respectively wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dwReq | input | 1 | Data write request |
| dwAddr | input | 32 | Data write address |
| dwData | input | 32 | Data write value |
| pwReq | input | 1 | Program write request |
| pwAddr | input | 22 | Program write address |
| pwData | input | 32 | Program write value |
| drReq | input | 1 | Data read request |
| drAddr | input | 32 | Data read address |
| drData | output | 32 | Data read result |
| prReq | input | 1 | Program read request |
| prAddr | input | 22 | Program read address |
| prData | output | 32 | Program read result |
| ftReq | input | 1 | Instruction fetch request |
| ftAddr | input | 22 | Fetch address |
| ftData | output | 32 | Fetched word |
| grant | output | 5 | One-hot winner |
| stall | output | 5 | Per-source stall |
| memEn | output | 1 | Port access strobe |
| memWe | output | 1 | Port write strobe |
| memAddr | output | 32 | Port address |
| memWdata | output | 32 | Port write data |
| memRdata | input | 32 | Port read data |
| memReady | input | 1 | Port completes the access this cycle |

## Verification
Several properties are checked in every cycle: the one-hot grant, that a grant always goes to a requester, the silence of an idle port, the stall of each loser, the zero upper address bits for program-side winners, the write strobe, the data writer winning whenever no access is held, and the frozen grant across a ready-low stretch. Only the bench's scenarios show the full ranking across all legal request combinations. The same holds for the exact routing of addresses, write data and read data for each winner, for the release of a hold when the held source withdraws, and for the outcome when a forbidden pair is driven on purpose.

// File: rtl/harvardArbPkg.sv
package harvardArbPkg;
  localparam int NUM_SRC = 5;
  // Index order is the ranking: lower index wins
  localparam int SRC_DW = 0;
  localparam int SRC_PW = 1;
  localparam int SRC_DR = 2;
  localparam int SRC_PR = 3;
  localparam int SRC_FT = 4;

  typedef logic [NUM_SRC-1:0] srcVec_t;

  typedef struct packed {
    srcVec_t sel;
    logic    en;
    logic    we;
  } portCtl_t;
endpackage

// File: rtl/harvardArbCtrl.sv
module harvardArbCtrl
  import harvardArbPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  srcVec_t  req,
  input  logic     memReady,
  output portCtl_t ctl,
  output srcVec_t  stall
);
  srcVec_t prioSel;
  srcVec_t sel;
  srcVec_t heldSel_q;
  logic    holdValid_q;
  logic    holdHit;

  // Fixed ranking: the lowest requesting index wins
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      prioSel[i] = req[i] & ~seen;
      seen       = seen | req[i];
    end
  end

  // A held access keeps the port while its owner still asks
  assign holdHit = holdValid_q & (|(heldSel_q & req));
  assign sel     = holdHit ? heldSel_q : prioSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid_q <= 1'b0;
      heldSel_q   <= '0;
    end else begin
      holdValid_q <= (|sel) & ~memReady;
      if ((|sel) && !memReady) begin
        heldSel_q <= sel;
      end
    end
  end

  assign ctl.sel = sel;
  assign ctl.en  = |sel;
  assign ctl.we  = sel[SRC_DW] | sel[SRC_PW];

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_stall
      assign stall[i] = req[i] & ~(sel[i] & memReady);
    end
  endgenerate
endmodule

// File: rtl/harvardArbPath.sv
module harvardArbPath
  import harvardArbPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PROG_ADDR_W = 22,
  parameter int DATA_W      = 32
) (
  input  portCtl_t                 ctl,
  input  logic [ADDR_W-1:0]        dwAddr,
  input  logic [DATA_W-1:0]        dwData,
  input  logic [PROG_ADDR_W-1:0]   pwAddr,
  input  logic [DATA_W-1:0]        pwData,
  input  logic [ADDR_W-1:0]        drAddr,
  input  logic [PROG_ADDR_W-1:0]   prAddr,
  input  logic [PROG_ADDR_W-1:0]   ftAddr,
  input  logic [DATA_W-1:0]        memRdata,
  output logic                     memEn,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWdata,
  output logic [DATA_W-1:0]        drData,
  output logic [DATA_W-1:0]        prData,
  output logic [DATA_W-1:0]        ftData
);
  localparam int ZPAD_W = ADDR_W - PROG_ADDR_W;

  logic [ADDR_W-1:0] srcAddr [NUM_SRC];

  assign srcAddr[SRC_DW] = dwAddr;
  assign srcAddr[SRC_PW] = {{ZPAD_W{1'b0}}, pwAddr};
  assign srcAddr[SRC_DR] = drAddr;
  assign srcAddr[SRC_PR] = {{ZPAD_W{1'b0}}, prAddr};
  assign srcAddr[SRC_FT] = {{ZPAD_W{1'b0}}, ftAddr};

  // AND-OR mux driven by the one-hot select
  always_comb begin
    memAddr = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      memAddr = memAddr | (srcAddr[i] & {ADDR_W{ctl.sel[i]}});
    end
  end

  assign memEn    = ctl.en;
  assign memWe    = ctl.we;
  assign memWdata = ({DATA_W{ctl.sel[SRC_DW]}} & dwData) |
                    ({DATA_W{ctl.sel[SRC_PW]}} & pwData);

  assign drData = {DATA_W{ctl.sel[SRC_DR]}} & memRdata;
  assign prData = {DATA_W{ctl.sel[SRC_PR]}} & memRdata;
  assign ftData = {DATA_W{ctl.sel[SRC_FT]}} & memRdata;
endmodule

// File: rtl/harvardPortArbiter.sv
module harvardPortArbiter
  import harvardArbPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PROG_ADDR_W = 22,
  parameter int DATA_W      = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dwReq,
  input  logic [ADDR_W-1:0]      dwAddr,
  input  logic [DATA_W-1:0]      dwData,
  input  logic                   pwReq,
  input  logic [PROG_ADDR_W-1:0] pwAddr,
  input  logic [DATA_W-1:0]      pwData,
  input  logic                   drReq,
  input  logic [ADDR_W-1:0]      drAddr,
  output logic [DATA_W-1:0]      drData,
  input  logic                   prReq,
  input  logic [PROG_ADDR_W-1:0] prAddr,
  output logic [DATA_W-1:0]      prData,
  input  logic                   ftReq,
  input  logic [PROG_ADDR_W-1:0] ftAddr,
  output logic [DATA_W-1:0]      ftData,
  output logic [NUM_SRC-1:0]     grant,
  output logic [NUM_SRC-1:0]     stall,
  output logic                   memEn,
  output logic                   memWe,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memWdata,
  input  logic [DATA_W-1:0]      memRdata,
  input  logic                   memReady
);
  srcVec_t  reqVec;
  portCtl_t ctl;

  assign reqVec = {ftReq, prReq, drReq, pwReq, dwReq};
  assign grant  = ctl.sel;

  harvardArbCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .req      (reqVec),
    .memReady (memReady),
    .ctl      (ctl),
    .stall    (stall)
  );

  harvardArbPath #(
    .ADDR_W      (ADDR_W),
    .PROG_ADDR_W (PROG_ADDR_W),
    .DATA_W      (DATA_W)
  ) path_i (
    .ctl      (ctl),
    .dwAddr   (dwAddr),
    .dwData   (dwData),
    .pwAddr   (pwAddr),
    .pwData   (pwData),
    .drAddr   (drAddr),
    .prAddr   (prAddr),
    .ftAddr   (ftAddr),
    .memRdata (memRdata),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .drData   (drData),
    .prData   (prData),
    .ftData   (ftData)
  );
endmodule

// File: rtl/harvardArbChecker.sv
module harvardArbChecker #(
  parameter int ADDR_W      = 32,
  parameter int PROG_ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              dwReq,
  input logic              pwReq,
  input logic              drReq,
  input logic              prReq,
  input logic              ftReq,
  input logic [4:0]        grant,
  input logic [4:0]        stall,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReady
);
  logic [4:0] reqVec;
  assign reqVec = {ftReq, prReq, drReq, pwReq, dwReq};

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R2

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~reqVec) == 5'b0); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec == 5'b0) |-> (!memEn && grant == 5'b0)); // R2

  AST_LOSER_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec & ~grant & ~stall) == 5'b0); // R3

  AST_DW_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (dwReq && !$past(memEn && !memReady)) |-> grant[0]); // R1

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memEn && !memReady) && (($past(grant) & reqVec) != 5'b0))
      |-> (grant == $past(grant))); // R4

  AST_PROG_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    (grant[1] || grant[3] || grant[4]) |-> (memAddr[ADDR_W-1:PROG_ADDR_W] == '0)); // R5

  AST_WE_WRITERS: assert property (@(posedge clk) disable iff (!rstN)
    memWe == (grant[0] || grant[1])); // R6

  AST_READY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memReady) |-> ((stall & grant) == 5'b0)); // R8
endmodule

bind harvardPortArbiter harvardArbChecker #(
  .ADDR_W      (ADDR_W),
  .PROG_ADDR_W (PROG_ADDR_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .dwReq    (dwReq),
  .pwReq    (pwReq),
  .drReq    (drReq),
  .prReq    (prReq),
  .ftReq    (ftReq),
  .grant    (grant),
  .stall    (stall),
  .memEn    (memEn),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memReady (memReady)
);

// File: tb/harvardPortArbiter_tb.sv
`timescale 1ns/1ps
module harvardPortArbiter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dwReq = 0, pwReq = 0, drReq = 0, prReq = 0, ftReq = 0;
  logic [31:0] dwAddr = 32'h8000_1234, dwData = 32'hDEAD_0001;
  logic [21:0] pwAddr = 22'h3A_BCDE;
  logic [31:0] pwData = 32'h0BEE_0002;
  logic [31:0] drAddr = 32'hC000_0040;
  logic [21:0] prAddr = 22'h15_5555, ftAddr = 22'h0F_0F0F;
  logic [31:0] drData, prData, ftData, memAddr, memWdata, memRdata;
  logic [4:0]  grant, stall;
  logic        memEn, memWe;
  logic        memReady = 1'b1;

  int errors = 0;
  int checks = 0;
  bit illegalOk = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // Memory model: read word derived from the address
  assign memRdata = memAddr ^ 32'h5A5A_F00F;

  harvardPortArbiter dut_i (
    .clk(clk), .rstN(rstN),
    .dwReq(dwReq), .dwAddr(dwAddr), .dwData(dwData),
    .pwReq(pwReq), .pwAddr(pwAddr), .pwData(pwData),
    .drReq(drReq), .drAddr(drAddr), .drData(drData),
    .prReq(prReq), .prAddr(prAddr), .prData(prData),
    .ftReq(ftReq), .ftAddr(ftAddr), .ftData(ftData),
    .grant(grant), .stall(stall),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Forbidden pairs are flagged unless a scenario drives them on purpose (R9)
  always @(posedge clk) begin
    if (rstN && !illegalOk && ((dwReq && pwReq) || (prReq && ftReq))) begin
      checks++;
      errors++;
      $display("FAIL R9 forbidden pair seen: actual=%b expected=no pair",
               {ftReq, prReq, drReq, pwReq, dwReq});
    end
  end

  task automatic setReq(input logic [4:0] v);
    {ftReq, prReq, drReq, pwReq, dwReq} = v;
  endtask

  function automatic logic [31:0] expAddr(input logic [4:0] g);
    case (g)
      5'b00001: return dwAddr;
      5'b00010: return {10'b0, pwAddr};
      5'b00100: return drAddr;
      5'b01000: return {10'b0, prAddr};
      5'b10000: return {10'b0, ftAddr};
      default:  return 32'h0;
    endcase
  endfunction

  // One cycle with ready high, full check of the port and returns
  task automatic checkArb(input logic [4:0] v, input string grantTag);
    logic [4:0]  g;
    logic [31:0] ea, ew, md;
    @(negedge clk);
    setReq(v);
    memReady = 1'b1;
    #1;
    g  = v & (~v + 5'd1);
    ea = expAddr(g);
    md = ea ^ 32'h5A5A_F00F;
    ew = g[0] ? dwData : (g[1] ? pwData : 32'h0);
    check(grant == g, grantTag, "grant", 32'(grant), 32'(g));
    check(memEn == (g != 0), "R2", "memEn", 32'(memEn), 32'(g != 0));
    check(stall == (v & ~g), "R3", "stall", 32'(stall), 32'(v & ~g));
    check(memAddr == ea, "R5", "memAddr", memAddr, ea);
    check(memWe == (g[0] | g[1]), "R6", "memWe", 32'(memWe), 32'(g[0] | g[1]));
    check(memWdata == ew, "R6", "memWdata", memWdata, ew);
    check(drData == (g[2] ? md : 32'h0), "R7", "drData", drData, g[2] ? md : 32'h0);
    check(prData == (g[3] ? md : 32'h0), "R7", "prData", prData, g[3] ? md : 32'h0);
    check(ftData == (g[4] ? md : 32'h0), "R7", "ftData", ftData, g[4] ? md : 32'h0);
    if (g != 0) check((stall & g) == 0, "R8", "winner stall", 32'(stall & g), 32'h0);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    setReq(5'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(grant == 5'b0, "R2", "reset grant", 32'(grant), 32'h0);
    check(memEn == 1'b0, "R2", "reset memEn", 32'(memEn), 32'h0);
    check(stall == 5'b0, "R3", "reset stall", 32'(stall), 32'h0);
    rstN = 1'b1;
  endtask

  // Every legal request pattern with ready high: ranking R1, idle R2
  task automatic tRanking();
    for (int v = 0; v < 32; v++) begin
      logic [4:0] vv;
      vv = 5'(v);
      if ((vv[0] && vv[1]) || (vv[3] && vv[4])) continue;
      checkArb(vv, (vv == 0) ? "R2" : "R1");
    end
    @(negedge clk);
    setReq(5'b0);
  endtask

  // Ready-low hold and release (R4)
  task automatic tHold();
    @(negedge clk);
    setReq(5'b01000);
    memReady = 1'b0;
    #1;
    check(grant == 5'b01000, "R4", "first wait grant", 32'(grant), 32'h08);
    check(stall == 5'b01000, "R4", "winner stalls on wait", 32'(stall), 32'h08);
    check(memAddr == {10'b0, prAddr}, "R5", "held addr", memAddr, {10'b0, prAddr});
    @(negedge clk);
    setReq(5'b01001);
    #1;
    check(grant == 5'b01000, "R4", "hold vs data write", 32'(grant), 32'h08);
    check(stall == 5'b01001, "R4", "both stall", 32'(stall), 32'h09);
    @(negedge clk);
    memReady = 1'b1;
    #1;
    check(grant == 5'b01000, "R4", "hold at completion", 32'(grant), 32'h08);
    check(stall == 5'b00001, "R4", "only writer stalls", 32'(stall), 32'h01);
    check(prData == ({10'b0, prAddr} ^ 32'h5A5A_F00F), "R7", "held read data",
          prData, {10'b0, prAddr} ^ 32'h5A5A_F00F);
    @(negedge clk);
    #1;
    check(grant == 5'b00001, "R1", "ranking after release", 32'(grant), 32'h01);
    check(stall == 5'b01000, "R3", "reader stalls after release", 32'(stall), 32'h08);
    // Held source withdraws: hold dropped
    @(negedge clk);
    setReq(5'b00100);
    memReady = 1'b0;
    #1;
    check(grant == 5'b00100, "R4", "data read waits", 32'(grant), 32'h04);
    @(negedge clk);
    setReq(5'b01000);
    #1;
    check(grant == 5'b01000, "R4", "withdrawn hold dropped", 32'(grant), 32'h08);
    @(negedge clk);
    memReady = 1'b1;
    setReq(5'b0);
    #1;
    check(memEn == 1'b0, "R2", "idle after hold", 32'(memEn), 32'h0);
  endtask

  // Forbidden pairs driven on purpose (R9)
  task automatic tForbidden();
    illegalOk = 1;
    checkArb(5'b00011, "R9");
    checkArb(5'b11000, "R9");
    checkArb(5'b11011, "R9");
    checkArb(5'b11110, "R9");
    @(negedge clk);
    setReq(5'b0);
    #1;
    illegalOk = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tReset();
    tRanking();
    tHold();
    tForbidden();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule